// File: doc/BRIEF.md
# I2C SCL Rate and SDA-Hold Generator

This block derives the serial clock timing of an I2C master from the system bus clock. An 8-bit control word sets two things. A 2-bit multiplier selector picks a factor. A 6-bit rate code picks an SCL divider and an SDA hold count from a table computed inside the block. While enabled, the block drives a free-running SCL waveform whose period is the factor times the divider, in bus clocks. Each period has a low half followed by a high half of equal length.

Alongside the clock, the block gives the data path two one-cycle strobes. The first marks each SCL falling edge. The second marks the moment SDA may change, which is a fixed number of bus clocks after each falling edge, set by the hold count. The control word is sampled only when a new period begins, so a rewrite never shortens a half period. While disabled, SCL rests high and no strobes are issued. Enabling the block restarts the timing from zero.

Top module: `scl_rate_gen`

## Requirements
- R1: `cfg[7:6]` selects the multiplier factor: 2'b00 gives 1, 2'b01 gives 2, 2'b10 gives 4, and the reserved value 2'b11 gives 1. `cfg[5:0]` is the rate code.
- R2: The SCL divider for rate code c is computed as follows. For c <= 11 it is 18 + 2*max(c,1). For c >= 12, with d = c - 11, it is 40 + d*(d+21) + 2*(d/26), using integer division. The table therefore runs from 20 at code 0 to 3840 at code 63, and code 11 gives 40.
- R3: The SDA hold count for a code is divider/4 - 1, using integer division. Code 11 gives 9.
- R4: One SCL period lasts P = factor*divider bus clocks, measured between consecutive `scl_fall` pulses. SCL is low for the first P/2 cycles and high for the remaining P/2 cycles.
- R5: `scl_fall` is a one-cycle pulse in the first cycle in which `scl` is low. There is exactly one such pulse per period.
- R6: `sda_chg` is a one-cycle pulse issued exactly hold-count cycles after each `scl_fall` pulse. There is one per period, and it always falls while SCL is low.
- R7: While `rst` is high, or in the cycle after a clock edge that saw `en` low, `scl` is 1 and both strobes are 0. The value of `cfg` has no effect during this time.
- R8: At the first clock edge that sees `en` high after being disabled, `scl` goes low with a `scl_fall` pulse, and a full period follows.
- R9: `cfg` is sampled only at the start of a period. A change made mid-period leaves the current period unchanged and takes effect from the next period.
- R10: With `cfg` = 8'h4B (factor 2, code 0x0B), the period is 80 bus clocks and the SDA hold count is 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run the SCL generator |
| cfg | input | 8 | Multiplier selector [7:6] and rate code [5:0] |
| scl | output | 1 | Registered SCL level |
| scl_fall | output | 1 | One-cycle pulse on each SCL falling edge |
| sda_chg | output | 1 | One-cycle pulse when SDA may change |

## Verification
Four properties are checked on every clock. The period position never reaches the latched period length. The latched settings stay stable inside a period. Each falling-edge pulse coincides with a real high-to-low transition. The SDA strobe only appears while SCL is low. In addition, a disabled cycle always leaves SCL high and quiet, and enabling always opens with a falling-edge pulse. The actual cycle counts can only be shown by the bench's scenarios, including the per-code divider and hold values, the multiplier mapping with its reserved code, and the deferred effect of a mid-period rewrite. The bench measures these against periods it computes itself.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  // SCL divider for a rate code: non-decreasing, even, 20..3840
  function automatic int rate_divider(input int code);
    int d;
    if (code <= 11) return 18 + 2 * ((code < 1) ? 1 : code);
    d = code - 11;
    return 40 + d * (d + 21) + 2 * (d / 26);
  endfunction

  // SDA hold count derived from the divider, always below divider/2
  function automatic int hold_count(input int div);
    return div / 4 - 1;
  endfunction

  // Multiplier selector to left-shift amount; reserved code acts as x1
  function automatic logic [1:0] mult_shift(input logic [1:0] sel);
    case (sel)
      2'b01:   return 2'd1;
      2'b10:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/sclgen_lut.sv
module sclgen_lut
  import sclgen_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int DIV_W  = 12,
  parameter int HOLD_W = 10
) (
  input  logic [CODE_W-1:0] code,
  output logic [DIV_W-1:0]  div,
  output logic [HOLD_W-1:0] hold
);
  localparam int ROM_N = 1 << CODE_W;

  logic [DIV_W-1:0]  div_rom  [ROM_N];
  logic [HOLD_W-1:0] hold_rom [ROM_N];

  for (genvar i = 0; i < ROM_N; i++) begin : g_rom
    assign div_rom[i]  = DIV_W'(rate_divider(i));
    assign hold_rom[i] = HOLD_W'(hold_count(rate_divider(i)));
  end

  assign div  = div_rom[code];
  assign hold = hold_rom[code];
endmodule

// File: rtl/sclgen_scale.sv
module sclgen_scale
  import sclgen_pkg::*;
#(
  parameter int DIV_W = 12,
  parameter int PER_W = DIV_W + 2
) (
  input  logic [1:0]       mul_sel,
  input  logic [DIV_W-1:0] div,
  output logic [PER_W-1:0] per,
  output logic [PER_W-1:0] half
);
  logic [1:0] sh;
  assign sh   = mult_shift(mul_sel);
  assign per  = PER_W'(div) << sh;
  assign half = per >> 1;
endmodule

// File: rtl/sclgen_timer.sv
module sclgen_timer #(
  parameter int PER_W  = 14,
  parameter int HOLD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [PER_W-1:0]  per_in,
  input  logic [PER_W-1:0]  half_in,
  input  logic [HOLD_W-1:0] hold_in,
  output logic              start_n,
  output logic [PER_W-1:0]  pos_n,
  output logic [PER_W-1:0]  half_n,
  output logic [HOLD_W-1:0] hold_n
);
  logic              run_q;
  logic [PER_W-1:0]  pos_q, per_q, half_q, per_n;
  logic [HOLD_W-1:0] hold_q;
  logic              wrap;

  assign wrap    = (pos_q == per_q - PER_W'(1));
  assign start_n = en && (!run_q || wrap);

  always_comb begin
    if (start_n) begin
      pos_n  = '0;
      per_n  = per_in;
      half_n = half_in;
      hold_n = hold_in;
    end else begin
      pos_n  = pos_q + PER_W'(1);
      per_n  = per_q;
      half_n = half_q;
      hold_n = hold_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run_q  <= 1'b0;
      pos_q  <= '0;
      per_q  <= '0;
      half_q <= '0;
      hold_q <= '0;
    end else begin
      run_q  <= 1'b1;
      pos_q  <= pos_n;
      per_q  <= per_n;
      half_q <= half_n;
      hold_q <= hold_n;
    end
  end

  assert_pos_in_period_R4: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (pos_q < per_q));

  assert_cfg_held_R9: assert property (@(posedge clk) disable iff (rst)
    (run_q && en && !wrap) |=> (per_q == $past(per_q) && hold_q == $past(hold_q)));
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int CODE_W = 6,
  parameter int DIV_W  = 12,
  parameter int HOLD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CODE_W+1:0] cfg,
  output logic              scl,
  output logic              scl_fall,
  output logic              sda_chg
);
  localparam int PER_W = DIV_W + 2;

  logic [DIV_W-1:0]  div;
  logic [HOLD_W-1:0] hold, hold_n;
  logic [PER_W-1:0]  per, half, pos_n, half_n;
  logic              start_n;

  sclgen_lut #(.CODE_W(CODE_W), .DIV_W(DIV_W), .HOLD_W(HOLD_W)) u_lut (
    .code(cfg[CODE_W-1:0]), .div(div), .hold(hold)
  );

  sclgen_scale #(.DIV_W(DIV_W), .PER_W(PER_W)) u_scale (
    .mul_sel(cfg[CODE_W+1:CODE_W]), .div(div), .per(per), .half(half)
  );

  sclgen_timer #(.PER_W(PER_W), .HOLD_W(HOLD_W)) u_timer (
    .clk(clk), .rst(rst), .en(en),
    .per_in(per), .half_in(half), .hold_in(hold),
    .start_n(start_n), .pos_n(pos_n), .half_n(half_n), .hold_n(hold_n)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      scl      <= 1'b1;
      scl_fall <= 1'b0;
      sda_chg  <= 1'b0;
    end else begin
      scl      <= (pos_n >= half_n);
      scl_fall <= start_n;
      sda_chg  <= (pos_n == PER_W'(hold_n));
    end
  end

  assert_fall_is_edge_R5: assert property (@(posedge clk) disable iff (rst)
    scl_fall |-> (!scl && $past(scl)));

  assert_chg_while_low_R6: assert property (@(posedge clk) disable iff (rst)
    sda_chg |-> (!scl && !scl_fall));

  assert_idle_when_off_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (scl && !scl_fall && !sda_chg));

  assert_start_on_enable_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |=> scl_fall);
endmodule

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;
  logic       clk = 1'b0;
  logic       rst, en;
  logic [7:0] cfg;
  logic       scl, scl_fall, sda_chg;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  scl_rate_gen dut (.clk(clk), .rst(rst), .en(en), .cfg(cfg),
                    .scl(scl), .scl_fall(scl_fall), .sda_chg(sda_chg));

  function automatic int exp_div(input int c);
    if (c <= 11) return (c < 1) ? 20 : 18 + 2 * c;
    return 40 + (c - 11) * (c - 11 + 21) + 2 * ((c - 11) / 26);
  endfunction

  function automatic int exp_fac(input int m);
    return (m == 1) ? 2 : (m == 2) ? 4 : 1;
  endfunction

  function automatic int exp_per(input logic [7:0] v);
    return exp_fac(int'(v[7:6])) * exp_div(int'(v[5:0]));
  endfunction

  function automatic int exp_hold(input logic [7:0] v);
    return exp_div(int'(v[5:0])) / 4 - 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // R8: enable from idle; first sampled cycle must show the falling edge
  task automatic start_run(input logic [7:0] v);
    @(negedge clk); en = 1'b0; cfg = v;
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk("R8 scl low on enable", int'(scl), 0);
    chk("R8 fall pulse on enable", int'(scl_fall), 1);
  endtask

  // Observe one period after a sampled fall; optionally rewrite cfg mid-period
  task automatic run_period(input logic [7:0] v, input string tag,
                            input int swap_t, input logic [7:0] swap_v);
    int p, h, hd, fall_at, rise_at, chg_at, n_fall, n_chg, n_high;
    p = exp_per(v); h = p / 2; hd = exp_hold(v);
    fall_at = -1; rise_at = -1; chg_at = -1; n_fall = 0; n_chg = 0; n_high = 0;
    for (int t = 1; t <= p; t++) begin
      @(negedge clk);
      if (t == swap_t) cfg = swap_v;
      if (scl_fall) begin n_fall++; if (fall_at < 0) fall_at = t; end
      if (sda_chg)  begin n_chg++;  if (chg_at < 0) chg_at = t; end
      if (scl) begin n_high++; if (rise_at < 0) rise_at = t; end
    end
    chk({"R4 period ", tag}, fall_at, p);
    chk({"R4 high at half ", tag}, rise_at, h);
    chk({"R4 high length ", tag}, n_high, p - h);
    chk({"R5 one fall ", tag}, n_fall, 1);
    chk({"R6 hold delay R2 R3 ", tag}, chg_at, hd);
    chk({"R6 one strobe ", tag}, n_chg, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    int q, busy;
    logic [7:0] v;
    void'($urandom(32'd5150));
    rst = 1'b1; en = 1'b1; cfg = 8'h00;
    repeat (4) @(negedge clk);
    chk("R7 reset scl high", int'(scl), 1);
    chk("R7 reset no pulses", int'(scl_fall) + int'(sda_chg), 0);
    en = 1'b0; rst = 1'b0;

    // R10: factor 2, code 0x0B -> period 80, hold 9
    chk("R10 expected period", exp_per(8'h4B), 80);
    chk("R10 expected hold", exp_hold(8'h4B), 9);
    start_run(8'h4B); run_period(8'h4B, "R10 4B", 0, 8'h00);
    run_period(8'h4B, "R10 4B second", 0, 8'h00);

    // R2 lower end, R1 reserved multiplier acts as x1
    start_run(8'h00); run_period(8'h00, "R2 code0", 0, 8'h00);
    start_run(8'hC5); run_period(8'hC5, "R1 reserved mul", 0, 8'h00);
    start_run(8'h05); run_period(8'h05, "R1 mul x1", 0, 8'h00);
    start_run(8'h8C); run_period(8'h8C, "R1 mul x4 code12", 0, 8'h00);
    chk("R2 top code divider", exp_div(63), 3840);
    start_run(8'hBF); run_period(8'hBF, "R2 top code", 0, 8'h00);

    // R9: rewrite mid-period, effect only from the next period
    start_run(8'h00);
    run_period(8'h00, "R9 current period kept", 5, 8'h4B);
    run_period(8'h4B, "R9 next period new", 0, 8'h00);

    // R7: disable mid-period, cfg changes have no effect
    repeat (7) @(negedge clk);
    en = 1'b0;
    busy = 0;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      cfg = 8'(t * 37);
      if (!scl || scl_fall || sda_chg) busy++;
    end
    chk("R7 idle while disabled", busy, 0);
    start_run(8'h41); run_period(8'h41, "R8 restart", 0, 8'h00);

    // Constrained random settings
    for (int k = 0; k < 8; k++) begin
      q = int'($urandom_range(0, 47));
      v = {2'($urandom_range(0, 3)), 6'(q)};
      start_run(v);
      run_period(v, $sformatf("R1 R2 random cfg=%02h", v), 0, 8'h00);
    end

    finish_run();
  end
endmodule